// File: doc/BRIEF.md
# Memory Address and Data Register Interface

This block connects a processor's single internal bus to an external memory bus. It holds a word address register and a word data register. The address register takes its value only from the internal bus and always drives the external address lines. The data register has two separately gated inputs and two separately gated outputs. It can capture from the internal bus or from the memory read-data lines, and it can present its contents to the internal bus, to the memory write-data lines, or to both.

The control sequencer issues read and write commands as single-cycle pulses. The block keeps each one as a pending request on the memory bus until memory returns its completion pulse. Memory latency is variable: a cache hit answers in the first cycle the request is visible, and a miss answers later. When the sequencer asks to wait for completion and the pending request has not yet completed, the block raises a stall so that the sequencer holds its current control step. The stall is combinational, so a completion that arrives in the first wait cycle costs no extra cycle.

A typical indirect read takes three sequencer steps: address load with read command, then external capture with wait, then internal drive. A write takes three as well: address load, then internal capture with write command, then external drive with wait.

Top module: `mem_xfer_unit`

## Requirements
- R1: After reset the address and data registers are zero, both memory request lines are 0, stall is 0, and both data output enables are 0.
- R2: When `ld_addr` is 1 at a clock edge, the address register takes `ibus_in` and `mem_addr` shows it from the next cycle on. Otherwise the address register holds.
- R3: When `ld_data_int` is 1, `ld_data_ext` is 0 and `stall` is 0 at a clock edge, the data register takes `ibus_in`. While `stall` is 1, neither load input changes the data register.
- R4: When `ld_data_ext` is 1 and `stall` is 0 at a clock edge, the data register takes `mem_rdata`. This holds even when `ld_data_int` is also 1 in the same cycle.
- R5: `ibus_out` and `mem_wdata` always carry the data register value. `ibus_oe` follows `drv_data_int` and `mem_wdata_en` follows `drv_data_ext`, and the two enables are independent of each other.
- R6: A `rd_cmd` pulse makes `mem_rd` 1 from the next cycle. It stays 1 through the cycle in which `mem_done` is 1 and is 0 in the cycle after.
- R7: A `wr_cmd` pulse makes `mem_wr` 1 from the next cycle. It stays 1 through the cycle in which `mem_done` is 1 and is 0 in the cycle after.
- R8: At most one request is pending at a time. If `rd_cmd` and `wr_cmd` arrive together, the read is taken. A new command replaces a pending request of the other kind.
- R9: `stall` equals `wait_done` AND NOT `mem_done` AND (a request is pending). If `mem_done` is 1 in the first cycle of a wait, no stall cycle occurs.
- R10: A `mem_done` pulse with no request pending changes neither the request lines nor the registers. A `wait_done` with no request pending does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_in | input | WORD_W | Value currently on the internal bus |
| ld_addr | input | 1 | Load the address register from the internal bus |
| ld_data_int | input | 1 | Load the data register from the internal bus |
| ld_data_ext | input | 1 | Load the data register from the memory read data |
| drv_data_int | input | 1 | Gate the data register onto the internal bus |
| drv_data_ext | input | 1 | Gate the data register onto the memory write data |
| rd_cmd | input | 1 | Issue a memory read |
| wr_cmd | input | 1 | Issue a memory write |
| wait_done | input | 1 | Sequencer waits for memory completion in this step |
| mem_done | input | 1 | Memory reports that the pending operation is complete |
| mem_rdata | input | WORD_W | Memory read data lines |
| mem_addr | output | WORD_W | Memory address lines |
| mem_rd | output | 1 | Read request pending |
| mem_wr | output | 1 | Write request pending |
| mem_wdata | output | WORD_W | Memory write data lines |
| mem_wdata_en | output | 1 | Write data lines are driven |
| ibus_out | output | WORD_W | Data register value toward the internal bus |
| ibus_oe | output | 1 | Internal bus drive enable |
| stall | output | 1 | Hold the current control step |

## Verification
The hardest case to reach is a long-latency miss during which the load inputs stay high and the memory read lines carry junk. The data register must ignore every one of those cycles and then capture the real word in the cycle in which completion arrives. The stimulus holds the wait and external-load inputs for several cycles with changing junk on `mem_rdata`, checks that the stall stays high in each of them, and then raises `mem_done` together with the real word. A hit case, where completion comes in the first wait cycle, is set against it to show that no stall cycle appears.

// File: rtl/mxu_pkg.sv
package mxu_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
  } req_t;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INT  = 2'd1,
    SRC_EXT  = 2'd2
  } dsrc_t;

  // Next pending request: completion clears, a new command replaces, read wins a tie.
  function automatic req_t req_next(req_t cur, logic rd_cmd, logic wr_cmd, logic done);
    req_t n;
    n = cur;
    if (done) n = '0;
    if (rd_cmd) begin
      n.rd = 1'b1;
      n.wr = 1'b0;
    end else if (wr_cmd) begin
      n.wr = 1'b1;
      n.rd = 1'b0;
    end
    return n;
  endfunction

  function automatic logic stall_eval(logic wait_req, logic done, req_t cur);
    return wait_req & ~done & (cur.rd | cur.wr);
  endfunction

  // Data register source: external side has priority; nothing loads while stalled.
  function automatic dsrc_t data_src(logic ld_int, logic ld_ext, logic stalled);
    if (stalled)     return SRC_HOLD;
    else if (ld_ext) return SRC_EXT;
    else if (ld_int) return SRC_INT;
    else             return SRC_HOLD;
  endfunction

endpackage

// File: rtl/mxu_addr_reg.sv
module mxu_addr_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

endmodule

// File: rtl/mxu_data_reg.sv
module mxu_data_reg
  import mxu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_int,
  input  logic              ld_ext,
  input  logic              stalled,
  input  logic [WORD_W-1:0] int_d,
  input  logic [WORD_W-1:0] ext_d,
  output logic [WORD_W-1:0] q
);

  dsrc_t src;

  always_comb src = data_src(ld_int, ld_ext, stalled);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else begin
      case (src)
        SRC_INT: q <= int_d;
        SRC_EXT: q <= ext_d;
        default: q <= q;
      endcase
    end
  end

  // R3
  data_frozen_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> (q == $past(q)));

  // R4
  data_ext_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ext && !stalled) |=> (q == $past(ext_d)));

endmodule

// File: rtl/mxu_req_ctrl.sv
module mxu_req_ctrl
  import mxu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cmd,
  input  logic wr_cmd,
  input  logic wait_req,
  input  logic done,
  output logic pend_rd,
  output logic pend_wr,
  output logic stall_o
);

  req_t cur, nxt;

  always_comb begin
    nxt     = req_next(cur, rd_cmd, wr_cmd, done);
    stall_o = stall_eval(wait_req, done, cur);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign pend_rd = cur.rd;
  assign pend_wr = cur.wr;

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pend_rd, pend_wr}));

  // R6
  rd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd && !done && !wr_cmd) |=> pend_rd);

  // R7
  wr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && !done && !rd_cmd) |=> pend_wr);

  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd_cmd && !wr_cmd) |=> (!pend_rd && !pend_wr));

  // R9
  stall_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (pend_rd || pend_wr));

endmodule

// File: rtl/mem_xfer_unit.sv
module mem_xfer_unit #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ibus_in,
  input  logic              ld_addr,
  input  logic              ld_data_int,
  input  logic              ld_data_ext,
  input  logic              drv_data_int,
  input  logic              drv_data_ext,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              wait_done,
  input  logic              mem_done,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_wdata_en,
  output logic [WORD_W-1:0] ibus_out,
  output logic              ibus_oe,
  output logic              stall
);

  logic              hold_step;
  logic              req_rd;
  logic              req_wr;
  logic [WORD_W-1:0] data_q;

  mxu_req_ctrl u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .wr_cmd   (wr_cmd),
    .wait_req (wait_done),
    .done     (mem_done),
    .pend_rd  (req_rd),
    .pend_wr  (req_wr),
    .stall_o  (hold_step)
  );

  mxu_addr_reg #(.WORD_W(WORD_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld_addr),
    .d     (ibus_in),
    .q     (mem_addr)
  );

  mxu_data_reg #(.WORD_W(WORD_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_int  (ld_data_int),
    .ld_ext  (ld_data_ext),
    .stalled (hold_step),
    .int_d   (ibus_in),
    .ext_d   (mem_rdata),
    .q       (data_q)
  );

  assign mem_rd       = req_rd;
  assign mem_wr       = req_wr;
  assign stall        = hold_step;
  assign mem_wdata    = data_q;
  assign mem_wdata_en = drv_data_ext;
  assign ibus_out     = data_q;
  assign ibus_oe      = drv_data_int;

  // R9
  no_stall_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done |-> !stall);

  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |-> !stall);

endmodule

// File: tb/test_mem_xfer_unit.sv
module test_mem_xfer_unit;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] ibus_in, mem_rdata;
  logic         ld_addr, ld_data_int, ld_data_ext, drv_data_int, drv_data_ext;
  logic         rd_cmd, wr_cmd, wait_done, mem_done;
  logic [W-1:0] mem_addr, mem_wdata, ibus_out;
  logic         mem_rd, mem_wr, mem_wdata_en, ibus_oe, stall;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  mem_xfer_unit #(.WORD_W(W)) i_mem_xfer_unit (
    .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .ld_addr(ld_addr),
    .ld_data_int(ld_data_int), .ld_data_ext(ld_data_ext),
    .drv_data_int(drv_data_int), .drv_data_ext(drv_data_ext),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .wait_done(wait_done),
    .mem_done(mem_done), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_wdata_en(mem_wdata_en), .ibus_out(ibus_out), .ibus_oe(ibus_oe),
    .stall(stall)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_addr = 0; ld_data_int = 0; ld_data_ext = 0; drv_data_int = 0;
    drv_data_ext = 0; rd_cmd = 0; wr_cmd = 0; wait_done = 0; mem_done = 0;
  endtask

  // one clock edge, then settle at the falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 data", ibus_out, 0);
    chk("R1 mem_rd", W'(mem_rd), 0);
    chk("R1 mem_wr", W'(mem_wr), 0);
    chk("R1 stall", W'(stall), 0);
    chk("R1 ibus_oe", W'(ibus_oe), 0);
    chk("R1 wdata_en", W'(mem_wdata_en), 0);
  endtask

  task automatic t_addr();
    ibus_in = 32'hA5A5_0100; ld_addr = 1;
    cyc();
    ld_addr = 0; ibus_in = 32'h1111_2222;
    chk("R2 addr load", mem_addr, 32'hA5A5_0100);
    cyc();
    chk("R2 addr hold", mem_addr, 32'hA5A5_0100);
  endtask

  task automatic t_read_hit();
    ibus_in = 32'h0000_0040; ld_addr = 1; rd_cmd = 1;
    cyc();
    idle();
    chk("R6 mem_rd up", W'(mem_rd), 1);
    chk("R2 read addr", mem_addr, 32'h0000_0040);
    wait_done = 1; ld_data_ext = 1; mem_done = 1; mem_rdata = 32'hCAFE_0001;
    settle();
    chk("R9 hit no stall", W'(stall), 0);
    cyc();
    idle();
    chk("R6 mem_rd cleared", W'(mem_rd), 0);
    drv_data_int = 1;
    settle();
    chk("R4 read data", ibus_out, 32'hCAFE_0001);
    chk("R5 ibus_oe", W'(ibus_oe), 1);
    chk("R5 wdata_en off", W'(mem_wdata_en), 0);
    cyc();
    idle();
  endtask

  task automatic t_read_miss();
    rd_cmd = 1;
    cyc();
    idle();
    for (int i = 0; i < 3; i++) begin
      wait_done = 1; ld_data_ext = 1; ld_data_int = 1;
      mem_rdata = 32'hDEAD_0000 + i; ibus_in = 32'hBEEF_0000 + i;
      settle();
      chk("R9 miss stall", W'(stall), 1);
      chk("R6 mem_rd held", W'(mem_rd), 1);
      cyc();
      chk("R3 no load in stall", ibus_out, 32'hCAFE_0001);
    end
    ld_data_int = 0; mem_done = 1; mem_rdata = 32'h7777_0002;
    settle();
    chk("R9 done ends stall", W'(stall), 0);
    cyc();
    idle();
    chk("R4 miss data", ibus_out, 32'h7777_0002);
    chk("R6 mem_rd after miss", W'(mem_rd), 0);
  endtask

  task automatic t_write();
    ibus_in = 32'h0000_0080; ld_addr = 1;
    cyc();
    idle();
    ibus_in = 32'h1234_5678; ld_data_int = 1; wr_cmd = 1;
    cyc();
    idle();
    chk("R7 mem_wr up", W'(mem_wr), 1);
    chk("R8 no read", W'(mem_rd), 0);
    drv_data_ext = 1; wait_done = 1;
    settle();
    chk("R3 write data", mem_wdata, 32'h1234_5678);
    chk("R5 wdata_en", W'(mem_wdata_en), 1);
    chk("R5 ibus_oe off", W'(ibus_oe), 0);
    chk("R9 write stall", W'(stall), 1);
    cyc();
    chk("R7 mem_wr held", W'(mem_wr), 1);
    mem_done = 1;
    settle();
    chk("R9 write done", W'(stall), 0);
    cyc();
    idle();
    chk("R7 mem_wr cleared", W'(mem_wr), 0);
  endtask

  task automatic t_priority();
    ibus_in = 32'h0101_0101; mem_rdata = 32'h0202_0202;
    ld_data_int = 1; ld_data_ext = 1;
    cyc();
    idle();
    chk("R4 ext over int", ibus_out, 32'h0202_0202);
    ibus_in = 32'h0303_0303; ld_data_int = 1;
    cyc();
    idle();
    chk("R3 int load", ibus_out, 32'h0303_0303);
  endtask

  task automatic t_cmd_conflict();
    rd_cmd = 1; wr_cmd = 1;
    cyc();
    idle();
    chk("R8 tie read", W'(mem_rd), 1);
    chk("R8 tie no write", W'(mem_wr), 0);
    wr_cmd = 1;
    cyc();
    idle();
    chk("R8 replace wr", W'(mem_wr), 1);
    chk("R8 replace rd off", W'(mem_rd), 0);
    mem_done = 1;
    cyc();
    idle();
    chk("R7 replaced cleared", W'(mem_wr), 0);
  endtask

  task automatic t_stray();
    mem_done = 1; wait_done = 1;
    settle();
    chk("R10 idle wait no stall", W'(stall), 0);
    cyc();
    idle();
    chk("R10 stray rd", W'(mem_rd), 0);
    chk("R10 stray wr", W'(mem_wr), 0);
    chk("R10 stray data", ibus_out, 32'h0303_0303);
    chk("R10 stray addr", mem_addr, 32'h0000_0080);
  endtask

  initial begin
    idle();
    ibus_in = '0; mem_rdata = '0; rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_addr();
    t_read_hit();
    t_read_miss();
    t_write();
    t_priority();
    t_cmd_conflict();
    t_stray();
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule